// File: doc/BRIEF.md
# Two-Queue FIFO Controller with Replay

This block manages one shared storage array as a first-in first-out buffer. After reset it runs as a single queue that spans the whole array. When the partition input is high, the array is split into two equal halves. Each half then behaves as an independent queue. A queue-select bit on the write side picks the queue to fill, and a queue-select bit on the read side picks the queue to drain. Both ports share one clock.

The read side can record a replay point while it reads a word. A later rewind pulse moves the read pointer back to that point, so the words from there onward are delivered again. A read taken while the output-disable input is high still consumes the word, but it returns nothing on the bus (read skip). A mailbox bypass carries write data straight to the read bus two clock edges later and blocks normal queue traffic while it is active.

Top module: `twoq_fifo`

## Requirements
- R1: With `mode_two_q` low, queue 0 holds DEPTH words. With `mode_two_q` high, queue 0 and queue 1 each hold DEPTH/2 words independently, and each queue returns its words in the order they were written.
- R2: A select value of 0 means queue 0 and 1 means queue 1. With `mode_two_q` low, a write or read with select 1 is dropped, and the flags then report queue 0.
- R3: `full_n` is low exactly when the queue named by `wr_qsel` is full. A write to a full queue is discarded.
- R4: `empty_n` is low exactly when the queue named by `rd_qsel` is empty. A read from an empty queue is discarded and gives no data-valid.
- R5: An accepted read with `rd_mark` high records that word's location as the replay point of the selected read queue. A `rd_rewind` pulse loads the replay point into the read pointer, so later reads deliver the earlier words again until they reach the written data. The rewind cycle itself performs no read.
- R6: An accepted read with `rd_oe_n` high advances the read pointer. In the next cycle `rd_bus_en` is low and both data-valid bits are high.
- R7: An accepted read with `rd_oe_n` low places the word on `rd_data` one edge later. In that same cycle it drives low only the `dval_n` bit of the queue read (bit 0 = queue 0, bit 1 = queue 1) and raises `rd_bus_en`.
- R8: Reset clears all pointers and replay points in both queues. After reset `full_n` is high, `empty_n` is low, `rd_data` is zero, `rd_bus_en` is low and `dval_n` is 2'b11.
- R9: While `mbox_en` is high, `wr_data` shows on `rd_data` after two rising edges with `rd_bus_en` high. No data-valid is raised for it, and queue writes and reads are blocked.
- R10: Once a replay point has been recorded, the queue counts as full when the words from the replay point to the write pointer fill its capacity. Data that can still be replayed is therefore never overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_two_q | input | 1 | 1 splits the array into two queues; change only during reset |
| wr_en | input | 1 | Write request |
| wr_qsel | input | 1 | Queue to write |
| wr_data | input | DATA_W | Write data, also the mailbox input |
| rd_en | input | 1 | Read request |
| rd_oe_n | input | 1 | Active-low output enable; high turns a read into a skip |
| rd_qsel | input | 1 | Queue to read, mark or rewind |
| rd_mark | input | 1 | Record the replay point on this read |
| rd_rewind | input | 1 | Load the replay point into the read pointer |
| mbox_en | input | 1 | Mailbox bypass active |
| full_n | output | 1 | Active-low full flag of the write-selected queue |
| empty_n | output | 1 | Active-low empty flag of the read-selected queue |
| rd_data | output | DATA_W | Registered read or mailbox data |
| rd_bus_en | output | 1 | High when `rd_data` should be driven onto the bus |
| dval_n | output | 2 | Active-low data-valid, one bit per queue |

## Verification
The hardest state to reach is a queue that reports full only because of the replay point, while its read pointer sits well ahead of it. The bench marks the second word and reads past it. It then rewinds and drains again, so the read pointer moves ahead while the replay point stays behind. Finally it writes until the flag drops. Counting from the read pointer alone, the queue would still have free room at that point, so the flag only falls if the fill is measured from the replay point. The two-queue case is reached by placing the partition input during reset. The bench then fills queue 0 to its half capacity while queue 1 still reports free space.

// File: rtl/twoq_pkg.sv
package twoq_pkg;
  localparam int NUM_Q = 2;
  typedef logic qid_t;
endpackage

// File: rtl/twoq_store.sv
module twoq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  // storage array: no reset, write under clock enable
  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/twoq_mbox.sv
module twoq_mbox #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mb_en,
  input  logic [DATA_W-1:0] din,
  output logic              stage_vld,
  output logic [DATA_W-1:0] stage_dat
);
  logic              vld_d;
  logic [DATA_W-1:0] dat_d;

  always_comb begin
    vld_d = mb_en;
    dat_d = stage_dat;
    if (mb_en) begin
      dat_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_vld <= 1'b0;
      stage_dat <= '0;
    end else begin
      stage_vld <= vld_d;
      stage_dat <= dat_d;
    end
  end
endmodule

// File: rtl/twoq_queue_ctl.sv
module twoq_queue_ctl #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] cap,
  input  logic          wr_go,
  input  logic          rd_go,
  input  logic          mark_go,
  input  logic          rewind_go,
  output logic [PW-1:0] wptr_o,
  output logic [PW-1:0] rptr_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [PW-1:0] wptr_q, wptr_d;
  logic [PW-1:0] rptr_q, rptr_d;
  logic [PW-1:0] mark_q, mark_d;
  logic          mact_q, mact_d;
  logic [PW-1:0] base;
  logic [PW-1:0] fill;

  // fill is measured from the replay point once one exists
  always_comb begin
    base    = mact_q ? mark_q : rptr_q;
    fill    = wptr_q - base;
    full_o  = (fill == cap);
    empty_o = (wptr_q == rptr_q);
  end

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    mark_d = mark_q;
    mact_d = mact_q;
    if (wr_go) begin
      wptr_d = wptr_q + PW'(1);
    end
    if (rewind_go) begin
      rptr_d = mark_q;
    end else if (rd_go) begin
      rptr_d = rptr_q + PW'(1);
      if (mark_go) begin
        mark_d = rptr_q;
        mact_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      mark_q <= '0;
      mact_q <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      mark_q <= mark_d;
      mact_q <= mact_d;
    end
  end

  assign wptr_o = wptr_q;
  assign rptr_o = rptr_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> !full_o) else $error("write into full queue"); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> !empty_o) else $error("read from empty queue"); // R4
  AST_REWIND_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_go |=> (rptr_q == $past(mark_q))) else $error("rewind target wrong"); // R5
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= cap) else $error("replay window exceeds capacity"); // R10
endmodule

// File: rtl/twoq_fifo.sv
module twoq_fifo
  import twoq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_two_q,
  input  logic              wr_en,
  input  logic              wr_qsel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_oe_n,
  input  logic              rd_qsel,
  input  logic              rd_mark,
  input  logic              rd_rewind,
  input  logic              mbox_en,
  output logic              full_n,
  output logic              empty_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bus_en,
  output logic [1:0]        dval_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] CAP_ONE = PW'(DEPTH);
  localparam logic [PW-1:0] CAP_TWO = PW'(DEPTH / 2);

  logic [PW-1:0] wptr_a [NUM_Q];
  logic [PW-1:0] rptr_a [NUM_Q];
  logic [NUM_Q-1:0] full_a, empty_a, hit_w, hit_r;
  logic [PW-1:0] cap;
  qid_t eff_wq, eff_rq;
  logic wsel_ok, rsel_ok, mb_busy, rd_kick;
  logic wr_acc, rd_acc, rewind_req;
  logic mb_vld;
  logic [DATA_W-1:0] mb_dat, mem_rd;
  logic [AW-1:0] waddr, raddr;
  logic [DATA_W-1:0] data_q, data_d;
  logic [1:0] dval_q, dval_d;
  logic bus_q, bus_d;

  function automatic logic [AW-1:0] phys(input logic two, input qid_t q,
                                         input logic [AW-1:0] p);
    if (two) phys = {q, p[AW-2:0]};
    else     phys = p;
  endfunction

  // queue selection and access qualification
  always_comb begin
    cap        = mode_two_q ? CAP_TWO : CAP_ONE;
    eff_wq     = mode_two_q & wr_qsel;
    eff_rq     = mode_two_q & rd_qsel;
    wsel_ok    = mode_two_q | ~wr_qsel;
    rsel_ok    = mode_two_q | ~rd_qsel;
    mb_busy    = mbox_en | mb_vld;
    rd_kick    = rsel_ok & ~mb_busy;
    wr_acc     = wr_en & wsel_ok & ~mbox_en & ~full_a[eff_wq];
    rewind_req = rd_kick & rd_rewind;
    rd_acc     = rd_kick & rd_en & ~rd_rewind & ~empty_a[eff_rq];
    full_n     = ~full_a[eff_wq];
    empty_n    = ~empty_a[eff_rq];
    waddr      = phys(mode_two_q, eff_wq, wptr_a[eff_wq][AW-1:0]);
    raddr      = phys(mode_two_q, eff_rq, rptr_a[eff_rq][AW-1:0]);
  end

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    assign hit_w[g] = (eff_wq == 1'(g));
    assign hit_r[g] = (eff_rq == 1'(g));
    twoq_queue_ctl #(.PW(PW)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap       (cap),
      .wr_go     (wr_acc & hit_w[g]),
      .rd_go     (rd_acc & hit_r[g]),
      .mark_go   (rd_acc & rd_mark & hit_r[g]),
      .rewind_go (rewind_req & hit_r[g]),
      .wptr_o    (wptr_a[g]),
      .rptr_o    (rptr_a[g]),
      .full_o    (full_a[g]),
      .empty_o   (empty_a[g])
    );
  end

  twoq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (wr_acc),
    .waddr (waddr),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (mem_rd)
  );

  twoq_mbox #(.DATA_W(DATA_W)) u_mbox (
    .clk       (clk),
    .rst_n     (rst_n),
    .mb_en     (mbox_en),
    .din       (wr_data),
    .stage_vld (mb_vld),
    .stage_dat (mb_dat)
  );

  // output register next state
  always_comb begin
    data_d = data_q;
    dval_d = 2'b11;
    bus_d  = bus_q;
    if (mb_vld) begin
      data_d = mb_dat;
      bus_d  = 1'b1;
    end else if (rd_acc) begin
      if (!rd_oe_n) begin
        data_d         = mem_rd;
        dval_d[eff_rq] = 1'b0;
        bus_d          = 1'b1;
      end else begin
        bus_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dval_q <= 2'b11;
      bus_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      dval_q <= dval_d;
      bus_q  <= bus_d;
    end
  end

  assign rd_data   = data_q;
  assign dval_n    = dval_q;
  assign rd_bus_en = bus_q;

  AST_DVAL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dval_n)) else $error("two data-valid bits low"); // R7
  AST_DVAL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !rd_oe_n) |=> (dval_n != 2'b11 && rd_bus_en)) else $error("read without valid"); // R7
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && rd_oe_n) |=> (dval_n == 2'b11 && !rd_bus_en)) else $error("skip drove bus"); // R6
  AST_MBOX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_en |=> (dval_n == 2'b11)) else $error("valid during mailbox"); // R9
endmodule

// File: tb/twoq_fifo_tb.sv
`timescale 1ns/1ps
module twoq_fifo_tb;
  localparam int W = 8;
  localparam int DEPTH = 16;

  logic clk, rst_n, mode_two_q, wr_en, wr_qsel, rd_en, rd_oe_n, rd_qsel;
  logic rd_mark, rd_rewind, mbox_en;
  logic [W-1:0] wr_data;
  logic full_n, empty_n, rd_bus_en;
  logic [W-1:0] rd_data;
  logic [1:0] dval_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  twoq_fifo #(.DATA_W(W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_two_q(mode_two_q), .wr_en(wr_en),
    .wr_qsel(wr_qsel), .wr_data(wr_data), .rd_en(rd_en), .rd_oe_n(rd_oe_n),
    .rd_qsel(rd_qsel), .rd_mark(rd_mark), .rd_rewind(rd_rewind),
    .mbox_en(mbox_en), .full_n(full_n), .empty_n(empty_n),
    .rd_data(rd_data), .rd_bus_en(rd_bus_en), .dval_n(dval_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // vector: wr_en | wdata | rd_en | oe_n | exp_valid | exp_data
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b1, 8'h33, 1'b1, 1'b0, 1'b1, 8'h11},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h22},
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00},
    {1'b1, 8'h44, 1'b1, 1'b0, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h44}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; rd_mark = 0; rd_rewind = 0; mbox_en = 0;
    rd_oe_n = 0; wr_qsel = 0; rd_qsel = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic two);
    idle();
    rst_n = 0;
    mode_two_q = two;
    tick(); tick();
    rst_n = 1;
    #1;
  endtask

  task automatic wr1(input logic q, input logic [W-1:0] d);
    idle(); wr_en = 1; wr_qsel = q; wr_data = d;
    tick(); idle();
  endtask

  task automatic rd1(input logic q, input logic mk, input string req,
                     input logic [W-1:0] expd);
    idle(); rd_en = 1; rd_qsel = q; rd_mark = mk;
    tick(); idle();
    chk(req, rd_data, expd);
    chk(req, dval_n, q ? 2'b01 : 2'b10);
  endtask

  initial begin
    wr_data = '0;
    do_reset(1'b0);
    // R8 reset state
    chk("R8 full_n", full_n, 1);
    chk("R8 empty_n", empty_n, 0);
    chk("R8 dval_n", dval_n, 2'b11);
    chk("R8 rd_data", rd_data, 0);
    chk("R8 bus_en", rd_bus_en, 0);

    // table walk: order, empty-drop R4, skip R6, valid R7
    for (int i = 0; i < NV; i++) begin
      idle();
      wr_en = VEC[i][19]; wr_data = VEC[i][18:11];
      rd_en = VEC[i][10]; rd_oe_n = VEC[i][9];
      tick();
      if (VEC[i][8]) begin
        chk("R7 vec dval", dval_n, 2'b10);
        chk("R1 vec data", rd_data, VEC[i][7:0]);
      end else begin
        chk("R4 R6 vec no-valid", dval_n, 2'b11);
        if (VEC[i][9]) chk("R6 skip bus", rd_bus_en, 0);
      end
    end
    idle(); #1;
    chk("R4 empty after table", empty_n, 0);

    // R3 single-queue fill to DEPTH, extra write discarded
    do_reset(1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3 not yet full", full_n, 1);
      wr1(0, 8'h80 + 8'(i));
    end
    #1; chk("R3 full at depth", full_n, 0);
    wr1(0, 8'hEE);
    for (int i = 0; i < DEPTH; i++) rd1(0, 0, "R3 R1 drain", 8'h80 + 8'(i));
    #1; chk("R3 extra write dropped", empty_n, 0);

    // R1 two-queue mode
    do_reset(1'b1);
    for (int i = 0; i < DEPTH/2; i++) wr1(0, 8'h40 + 8'(i));
    wr_qsel = 0; #1; chk("R1 q0 full at half", full_n, 0);
    wr_qsel = 1; #1; chk("R1 q1 still free", full_n, 1);
    idle();
    for (int i = 0; i < 3; i++) wr1(1, 8'hC0 + 8'(i));
    rd_qsel = 1; #1; chk("R4 q1 not empty", empty_n, 1);
    rd1(1, 0, "R7 R1 q1 read", 8'hC0);
    rd1(0, 0, "R7 R1 q0 read", 8'h40);
    rd1(1, 0, "R1 q1 order", 8'hC1);

    // R2 invalid select in single-queue mode
    do_reset(1'b0);
    wr1(1, 8'h77);
    #1; chk("R2 select1 write dropped", empty_n, 0);
    wr1(0, 8'h78);
    idle(); rd_en = 1; rd_qsel = 1; tick(); idle();
    chk("R2 select1 read dropped", dval_n, 2'b11);
    rd1(0, 0, "R2 q0 read after", 8'h78);

    // R5 mark and rewind, then R10 replay protection
    do_reset(1'b0);
    for (int i = 1; i <= 4; i++) wr1(0, 8'(i));
    rd1(0, 0, "R5 first", 8'h01);
    rd1(0, 1, "R5 marked", 8'h02);
    rd1(0, 0, "R5 third", 8'h03);
    idle(); rd_rewind = 1; tick(); idle();
    chk("R5 rewind no read", dval_n, 2'b11);
    #1; chk("R5 not empty after rewind", empty_n, 1);
    rd1(0, 0, "R5 replay 2", 8'h02);
    rd1(0, 0, "R5 replay 3", 8'h03);
    rd1(0, 0, "R5 replay 4", 8'h04);
    #1; chk("R5 empty at write ptr", empty_n, 0);
    for (int i = 0; i < 12; i++) wr1(0, 8'h90 + 8'(i));
    #1; chk("R10 room left", full_n, 1);
    wr1(0, 8'hA0);
    #1; chk("R10 full from mark", full_n, 0);

    // R9 mailbox
    do_reset(1'b0);
    idle(); mbox_en = 1; wr_en = 1; wr_data = 8'h5A;
    tick();
    chk("R9 not after one edge", rd_bus_en, 0);
    tick();
    chk("R9 data after two edges", rd_data, 8'h5A);
    chk("R9 bus driven", rd_bus_en, 1);
    chk("R9 no valid", dval_n, 2'b11);
    idle(); tick();
    chk("R9 write blocked", empty_n, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule